// File: doc/BRIEF.md
# Indirect Command Register Bridge

The bridge gives a host access to a small bank of byte-wide controller registers through a single packed 64-bit command word. To start an access, the host writes the word with its top bit (valid) set. The word carries an operation code, a 3-bit register selector, a direction bit and a 32-bit data field. While the access runs, valid reads back as 1. It drops to 0 once the access is done, so software finds out about completion by polling that bit.

Only operation code 6 reaches the internal register bus. For a write, the low data byte goes to the register picked by the selector. For a read, the returned byte is placed in the low byte of the data field and the rest of the data field is cleared. Selector 7 is soft reset: a write to it gives a one-cycle pulse to the attached controller and does not appear as a bus write. Any other operation code finishes at once with a zero data field. The address, size, combine and flag fields are kept exactly as written so the host can read them back.

Top module: `regcmd_bridge`

## Requirements
- R1: After reset the command word reads as all zeros, and no bus strobe or soft-reset pulse is active.
- R2: A host write with bit 63 set and operation code 6 (bits [60:57]) sets the read-back bit 63 for exactly ACCESS_CYCLES cycles (default 2), and then clears it.
- R3: A launched write (bit 56 = 0) with a selector (bits [34:32]) from 0 to 6 produces exactly one `ib_wr_en` pulse. During that pulse `ib_sel` equals the selector and `ib_wdata` equals bits [7:0]. The pulse comes in the last busy cycle.
- R4: A launched read (bit 56 = 1) produces exactly one `ib_rd_en` pulse. On completion, bits [7:0] hold the `ib_rdata` byte sampled during that pulse and bits [31:8] read as zero.
- R5: Bits [62:32] of a launched command read back unchanged after completion. After a write completes, bits [31:0] also read back unchanged.
- R6: A host write arriving while bit 63 is still set is ignored. The command in flight completes with its own selector and data.
- R7: A launched command whose operation code is not 6 reads back with bit 63 clear and bits [31:0] zero in the very next cycle, and it produces no bus strobe.
- R8: A launched write to selector 7 produces a one-cycle `soft_rst` pulse and no `ib_wr_en`.
- R9: A host write with bit 63 clear is stored as written and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes the command word this cycle |
| host_wr_data | input | 64 | Command word from the host |
| host_rd_data | output | 64 | Current command word, including the valid bit and the result |
| ib_sel | output | 3 | Internal register selector |
| ib_wr_en | output | 1 | Internal register write strobe |
| ib_rd_en | output | 1 | Internal register read strobe |
| ib_wdata | output | 8 | Internal register write byte |
| ib_rdata | input | 8 | Internal register read byte |
| soft_rst | output | 1 | One-cycle soft-reset pulse to the controller |

## Verification
The hardest case to reach is a second host write that lands while a command is still busy, because software normally waits for valid to drop first. The stimulus reaches it by issuing two commands on back-to-back cycles. A later read of the same register then shows that only the first command's byte was written. A scoreboard lists every bus strobe and soft-reset pulse each command should cause, so any extra strobe, including one from an ignored or non-local command, is reported.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam int unsigned CMD_W   = 64;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned OP_W    = 4;

    localparam logic [OP_W-1:0] OP_LOCAL_REG = 4'd6;

    typedef enum logic [SEL_W-1:0] {
        SEL_OWN_ADDR = 3'd0,
        SEL_DATA     = 3'd1,
        SEL_CTRL     = 3'd2,
        SEL_CLK_STAT = 3'd3,
        SEL_EXT_ADDR = 3'd4,
        SEL_RSVD5    = 3'd5,
        SEL_RSVD6    = 3'd6,
        SEL_SOFT_RST = 3'd7
    } reg_sel_e;

    // Packed command word, most significant field first.
    typedef struct packed {
        logic                 valid;     // 63
        logic                 slv_only;  // 62
        logic                 ext_flag;  // 61
        logic [OP_W-1:0]      opcode;    // 60:57
        logic                 is_read;   // 56
        logic                 ovr;       // 55
        logic [2:0]           size;      // 54:52
        logic [1:0]           combine;   // 51:50
        logic [9:0]           addr;      // 49:40
        logic [4:0]           sel_ext;   // 39:35
        logic [SEL_W-1:0]     sel;       // 34:32
        logic [DATA_W-1:0]    data;      // 31:0
    } cmd_word_t;

endpackage

// File: rtl/rcb_pacer.sv
module rcb_pacer #(
    parameter int unsigned CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    output logic last
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (busy && (cnt_q != LAST_CNT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = busy && (cnt_q == LAST_CNT);

endmodule

// File: rtl/rcb_port.sv
module rcb_port
    import rcb_pkg::*;
(
    input  logic               fire,
    input  logic               is_read,
    input  logic [SEL_W-1:0]   sel,
    input  logic [BYTE_W-1:0]  wbyte,
    output logic [SEL_W-1:0]   ib_sel,
    output logic               ib_wr_en,
    output logic               ib_rd_en,
    output logic [BYTE_W-1:0]  ib_wdata,
    output logic               soft_rst
);
    logic is_reset_sel;

    always_comb begin
        is_reset_sel = (sel == SEL_SOFT_RST);
        ib_sel       = sel;
        ib_wdata     = wbyte;
        ib_rd_en     = fire && is_read;
        ib_wr_en     = fire && !is_read && !is_reset_sel;
        soft_rst     = fire && !is_read && is_reset_sel;
    end

endmodule

// File: rtl/regcmd_bridge.sv
module regcmd_bridge
    import rcb_pkg::*;
#(
    parameter int unsigned ACCESS_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [63:0]       host_wr_data,
    output logic [63:0]       host_rd_data,
    output logic [2:0]        ib_sel,
    output logic              ib_wr_en,
    output logic              ib_rd_en,
    output logic [7:0]        ib_wdata,
    input  logic [7:0]        ib_rdata,
    output logic              soft_rst
);
    typedef struct packed {
        cmd_word_t word;
    } state_t;

    state_t    st_d, st_q;
    cmd_word_t incoming;
    logic      accept;
    logic      start;
    logic      last;

    rcb_pacer #(.CYCLES(ACCESS_CYCLES)) i_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (st_q.word.valid),
        .last  (last)
    );

    rcb_port i_port (
        .fire     (last),
        .is_read  (st_q.word.is_read),
        .sel      (st_q.word.sel),
        .wbyte    (st_q.word.data[BYTE_W-1:0]),
        .ib_sel   (ib_sel),
        .ib_wr_en (ib_wr_en),
        .ib_rd_en (ib_rd_en),
        .ib_wdata (ib_wdata),
        .soft_rst (soft_rst)
    );

    always_comb begin
        st_d     = st_q;
        incoming = cmd_word_t'(host_wr_data);
        accept   = host_wr_en && !st_q.word.valid;
        start    = accept && incoming.valid && (incoming.opcode == OP_LOCAL_REG);

        if (accept) begin
            st_d.word = incoming;
            if (incoming.valid && (incoming.opcode != OP_LOCAL_REG)) begin
                st_d.word.valid = 1'b0;
                st_d.word.data  = '0;
            end
        end else if (last) begin
            st_d.word.valid = 1'b0;
            if (st_q.word.is_read) begin
                st_d.word.data = {{(DATA_W-BYTE_W){1'b0}}, ib_rdata};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rd_data = st_q.word;

endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
    parameter int unsigned ACCESS_CYCLES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_en,
    input logic [63:0] host_wr_data,
    input logic [63:0] host_rd_data,
    input logic [2:0]  ib_sel,
    input logic        ib_wr_en,
    input logic        ib_rd_en,
    input logic [7:0]  ib_wdata,
    input logic [7:0]  ib_rdata,
    input logic        soft_rst
);
    logic [15:0] run_q;
    logic        strobe;

    assign strobe = ib_wr_en || ib_rd_en || soft_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (host_rd_data[63]) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R1: strobes are mutually exclusive
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ib_wr_en, ib_rd_en, soft_rst}) <= 1);

    // R2: busy window length
    a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rd_data[63]) |-> (run_q == 16'(ACCESS_CYCLES)));

    // R2: access ends the command
    a_r2_clear_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !host_rd_data[63]);

    // R3: strobes only while busy
    a_r3_strobe_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> host_rd_data[63]);

    // R3: write byte is the command's low byte
    a_r3_write_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ib_wr_en |-> (ib_wdata == host_rd_data[7:0] && ib_sel == host_rd_data[34:32]));

    // R4: read byte captured, upper data zero
    a_r4_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ib_rd_en |=> (host_rd_data[7:0] == $past(ib_rdata) && host_rd_data[31:8] == 24'd0));

    // R6: busy word does not move before its access
    a_r6_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data[63] && !strobe) |=> $stable(host_rd_data));

    // R8: soft reset only for selector 7
    a_r8_soft_sel: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (ib_sel == 3'd7 && !host_rd_data[56]));

    // R7: a non-local command is never left busy
    a_r7_no_busy_other_op: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !host_rd_data[63] && host_wr_data[60:57] != 4'd6)
            |=> !host_rd_data[63]);

endmodule

bind regcmd_bridge rcb_checker #(.ACCESS_CYCLES(ACCESS_CYCLES)) i_rcb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .host_rd_data (host_rd_data),
    .ib_sel       (ib_sel),
    .ib_wr_en     (ib_wr_en),
    .ib_rd_en     (ib_rd_en),
    .ib_wdata     (ib_wdata),
    .ib_rdata     (ib_rdata),
    .soft_rst     (soft_rst)
);

// File: tb/test_regcmd_bridge.sv
module test_regcmd_bridge;
    localparam int ACC = 2;
    localparam logic [7:0] STATUS_BYTE = 8'hF8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr_en;
    logic [63:0] host_wr_data;
    logic [63:0] host_rd_data;
    logic [2:0]  ib_sel;
    logic        ib_wr_en;
    logic        ib_rd_en;
    logic [7:0]  ib_wdata;
    logic [7:0]  ib_rdata;
    logic        soft_rst;

    int errors = 0;
    int checks = 0;

    typedef struct {
        int kind;   // 0 write, 1 read, 2 soft reset
        int sel;
        int data;
    } ev_t;
    ev_t expq[$];

    logic [7:0] regs [8];

    always #5 clk = ~clk;

    regcmd_bridge #(.ACCESS_CYCLES(ACC)) i_regcmd_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_data(host_rd_data), .ib_sel(ib_sel), .ib_wr_en(ib_wr_en),
        .ib_rd_en(ib_rd_en), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .soft_rst(soft_rst)
    );

    // Bench model of the internal registers; selector 3 reads as status.
    always_comb ib_rdata = (ib_sel == 3'd3) ? STATUS_BYTE : regs[ib_sel];
    always @(posedge clk) if (ib_wr_en) regs[ib_sel] <= ib_wdata;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every strobe must match the next expected event.
    always @(negedge clk) begin
        if (rst_n && (ib_wr_en || ib_rd_en || soft_rst)) begin
            int k;
            k = soft_rst ? 2 : (ib_rd_en ? 1 : 0);
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R3/R7 unexpected strobe actual=%0d expected=none", k);
            end else begin
                ev_t e;
                e = expq.pop_front();
                if (e.kind != k || e.sel != int'(ib_sel) ||
                    (k == 0 && e.data != int'(ib_wdata))) begin
                    errors++;
                    $display("FAIL R3 event actual=%0d/%0d/%h expected=%0d/%0d/%h",
                             k, ib_sel, ib_wdata, e.kind, e.sel, e.data[7:0]);
                end
            end
        end
    end

    function automatic logic [63:0] mk(input logic v, input logic rd, input logic [3:0] op,
                                       input logic [2:0] sel, input logic [31:0] d);
        return {v, 1'b1, 1'b0, op, rd, 1'b1, 3'd5, 2'd2, 10'h2B7, 5'h13, sel, d};
    endfunction

    task automatic expect_ev(input int kind, input int sel, input int data);
        ev_t e;
        e.kind = kind; e.sel = sel; e.data = data;
        expq.push_back(e);
    endtask

    task automatic launch(input logic [63:0] w);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (host_rd_data[63] && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] w;
        int n;
        for (int i = 0; i < 8; i++) regs[i] = 8'h00;
        rst_n = 1'b0;
        host_wr_en = 1'b0;
        host_wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 word", host_rd_data, 64'd0);
        chk("R1 strobes", {61'd0, ib_wr_en, ib_rd_en, soft_rst}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3, R5: write data register
        w = mk(1'b1, 1'b0, 4'd6, 3'd1, 32'h1234_56A5);
        expect_ev(0, 1, 'hA5);
        launch(w);
        wait_done(n);
        chk("R2 busy cycles", 64'(n), 64'(ACC));
        chk("R5 write readback", host_rd_data, {1'b0, w[62:0]});

        // R3: clock control write
        w = mk(1'b1, 1'b0, 4'd6, 3'd3, 32'h0000_003C);
        expect_ev(0, 3, 'h3C);
        launch(w);
        wait_done(n);
        chk("R2 busy cycles sel3", 64'(n), 64'(ACC));

        // R4: read data register back, junk in data field
        w = mk(1'b1, 1'b1, 4'd6, 3'd1, 32'hDEAD_BE00);
        expect_ev(1, 1, 0);
        launch(w);
        wait_done(n);
        chk("R4 read data", host_rd_data[31:0], 64'h0000_00A5);
        chk("R5 read fields", host_rd_data[63:32], {1'b0, w[62:32]});

        // R4: status read on selector 3
        w = mk(1'b1, 1'b1, 4'd6, 3'd3, 32'hFFFF_FFFF);
        expect_ev(1, 3, 0);
        launch(w);
        wait_done(n);
        chk("R4 status read", host_rd_data[31:0], {56'd0, STATUS_BYTE});

        // R6: second write while busy is dropped
        expect_ev(0, 2, 'h11);
        launch(mk(1'b1, 1'b0, 4'd6, 3'd2, 32'h0000_0011));
        launch(mk(1'b1, 1'b0, 4'd6, 3'd2, 32'h0000_0077));
        wait_done(n);
        chk("R6 word after ignore", host_rd_data[7:0], 64'h11);
        expect_ev(1, 2, 0);
        launch(mk(1'b1, 1'b1, 4'd6, 3'd2, 32'h0));
        wait_done(n);
        chk("R6 register kept first byte", host_rd_data[31:0], 64'h11);

        // R7: non-local opcode completes at once
        w = mk(1'b1, 1'b1, 4'd5, 3'd1, 32'hCAFE_F00D);
        launch(w);
        chk("R7 immediate", host_rd_data, {1'b0, w[62:32], 32'd0});
        repeat (3) @(negedge clk);
        chk("R7 stays idle", host_rd_data, {1'b0, w[62:32], 32'd0});

        // R8: soft reset selector
        expect_ev(2, 7, 0);
        launch(mk(1'b1, 1'b0, 4'd6, 3'd7, 32'h0000_00EE));
        wait_done(n);
        chk("R8 busy cycles", 64'(n), 64'(ACC));
        expect_ev(1, 7, 0);
        launch(mk(1'b1, 1'b1, 4'd6, 3'd7, 32'h0));
        wait_done(n);
        chk("R8 no register write", host_rd_data[31:0], 64'h0);

        // R9: valid clear stores word only
        w = mk(1'b0, 1'b0, 4'd6, 3'd4, 32'h0000_0099);
        launch(w);
        chk("R9 stored", host_rd_data, w);
        repeat (4) @(negedge clk);
        chk("R9 no launch", host_rd_data, w);

        repeat (3) @(negedge clk);
        chk("R3 all events seen", 64'(expq.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule